// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block gathers 16 or 32 external interrupt sources and presents the most urgent one to a processor. It is reached through a simple 32-bit register bus. Each source has a two-bit trigger mode: active low, active high, falling edge or rising edge. Each source also has a three-bit priority level. Level-mode sources show their synchronized input state. Edge-mode sources hold a sticky request bit until software clears that bit by index.

A source takes part in arbitration only if its level is strictly above one global mask level. A source at level 0 can therefore never fire. The source with the highest level wins, and on a tie the lowest index wins. The winner is published in a current-status word, and a single registered interrupt line is driven when the controller is enabled and some request passes the mask.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable, mask, level and mode registers all read 0. The current-status word reads 0x0001_0000 and `irqOut` is 0.
- R2: Byte address 0x00 holds the enable in bit 0. Address 0x40 holds the mask in bits 2:0. Each of these registers reads its unused bits as 0.
- R3: The eight level registers sit at 0x10, 0x14, ... 0x2C. The level of source n is held in register (n mod 16)/2, in bits [off+2:off], where off = (n/16)*16 + (n odd ? 8 : 0). Bits 7:3 of every byte lane read as 0.
- R4: The mode registers sit at 0x04 and 0x08. The mode of source n is held in register (n mod 16)/8, in bits [off+1:off], where off = (n mod 8)*2 + (n/16)*16. The modes are 00 active low, 01 active high, 10 falling edge and 11 rising edge.
- R5: In a level mode (bit 1 = 0), the request of a source follows its input after a two-flop synchronizer. The request is set when the input equals mode bit 0.
- R6: In an edge mode, the matching transition of the synchronized input sets a sticky request. The opposite transition does not set it, and the request stays set after the input returns to its idle state.
- R7: A write to 0x60 with bit 8 set clears the sticky request of the source whose index is in bits 4:0. A write with bit 8 clear changes nothing.
- R8: When an edge detection and a clear of the same source fall in the same clock cycle, the request stays set.
- R9: A source is eligible only when its request is set and its level is strictly greater than the mask.
- R10: The current-status word at 0xA0 has three fields. Bit 16 is set when no source is eligible. Otherwise bits 10:8 hold the winning level and bits 4:0 hold the winning index, with the highest level winning and the lowest index breaking a tie. All other bits read as 0.
- R11: `irqOut` is a register that is 1 exactly when the enable bit is set and some source is eligible. Clearing the enable bit forces `irqOut` to 0 but leaves the current-status word unchanged.
- R12: Address 0xA0 is not the only status view: the word at 0x80 returns the request bit of every source, with bit n for source n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational, 0 when not reading) |
| srcIn | input | NUM_SRC | Asynchronous interrupt inputs |
| irqOut | output | 1 | Registered interrupt request |

## Verification
An edge detection and a software clear of the same source can fall in the same cycle. The bench provokes this by raising a rising-edge input at a known falling clock edge, waiting two rising edges for the synchronizer, and timing the clear write to commit on the third edge, the cycle in which the latch sets. The case passes if the 0x80 and 0xA0 words still report that source afterwards. Random traffic is also judged against a bench model after every settle window: it mixes mask changes, level rewrites and clears while inputs toggle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W = 3;
  localparam int IDX_W = 5;

  localparam logic [7:0] ADDR_ENABLE   = 8'h00;
  localparam logic [7:0] ADDR_MODE0    = 8'h04;
  localparam logic [7:0] ADDR_MODE1    = 8'h08;
  localparam logic [7:0] ADDR_LVL_BASE = 8'h10;
  localparam logic [7:0] ADDR_LVL_LAST = 8'h2C;
  localparam logic [7:0] ADDR_MASK     = 8'h40;
  localparam logic [7:0] ADDR_CLEAR    = 8'h60;
  localparam logic [7:0] ADDR_SRCSTAT  = 8'h80;
  localparam logic [7:0] ADDR_CURSTAT  = 8'hA0;

  localparam int CLR_EN_BIT  = 8;
  localparam int NOREQ_BIT   = 16;
  localparam int LVL_REGS    = 8;
  localparam int MODE_REGS   = 2;

  typedef struct packed {
    logic                  wrEnable;
    logic [MODE_REGS-1:0]  wrMode;
    logic [LVL_REGS-1:0]   wrLevel;
    logic                  wrMask;
    logic                  clrEdge;
    logic [IDX_W-1:0]      clrIdx;
    logic [31:0]           wdata;
  } irqcStrobe_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                          busSel,
  input  logic                          busWrite,
  input  logic [7:0]                    busAddr,
  input  logic [31:0]                   busWdata,
  output logic [31:0]                   busRdata,
  output irqcStrobe_t                   stb,
  input  logic                          enBit,
  input  logic [LVL_W-1:0]              maskVal,
  input  logic [MODE_REGS-1:0][31:0]    modeImg,
  input  logic [LVL_REGS-1:0][31:0]     lvlImg,
  input  logic [NUM_SRC-1:0]            pendVec,
  input  logic [31:0]                   curStat
);
  logic       doWrite;
  logic       doRead;
  logic       inLvlRange;
  logic [7:0] lvlOff;
  logic [2:0] lvlSel;

  assign doWrite    = busSel & busWrite;
  assign doRead     = busSel & ~busWrite;
  assign lvlOff     = busAddr - ADDR_LVL_BASE;
  assign lvlSel     = lvlOff[4:2];
  assign inLvlRange = (busAddr >= ADDR_LVL_BASE) && (busAddr <= ADDR_LVL_LAST)
                      && (busAddr[1:0] == 2'b00);

  always_comb begin
    stb           = '0;
    stb.wdata     = busWdata;
    stb.clrIdx    = busWdata[IDX_W-1:0];
    stb.wrEnable  = doWrite && (busAddr == ADDR_ENABLE);
    stb.wrMode[0] = doWrite && (busAddr == ADDR_MODE0);
    stb.wrMode[1] = doWrite && (busAddr == ADDR_MODE1);
    stb.wrMask    = doWrite && (busAddr == ADDR_MASK);
    stb.clrEdge   = doWrite && (busAddr == ADDR_CLEAR) && busWdata[CLR_EN_BIT];
    for (int k = 0; k < LVL_REGS; k++) begin
      stb.wrLevel[k] = doWrite && inLvlRange && (lvlSel == 3'(k));
    end
  end

  always_comb begin
    busRdata = '0;
    if (doRead) begin
      if (inLvlRange) begin
        busRdata = lvlImg[lvlSel];
      end else begin
        case (busAddr)
          ADDR_ENABLE:  busRdata = {31'b0, enBit};
          ADDR_MODE0:   busRdata = modeImg[0];
          ADDR_MODE1:   busRdata = modeImg[1];
          ADDR_MASK:    busRdata = {{(32-LVL_W){1'b0}}, maskVal};
          ADDR_SRCSTAT: busRdata = 32'(pendVec);
          ADDR_CURSTAT: busRdata = curStat;
          default:      busRdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  irqcStrobe_t                 stb,
  input  logic [NUM_SRC-1:0]          srcIn,
  output logic                        enBit,
  output logic [LVL_W-1:0]            maskVal,
  output logic [MODE_REGS-1:0][31:0]  modeImg,
  output logic [LVL_REGS-1:0][31:0]   lvlImg,
  output logic [NUM_SRC-1:0]          pendVec,
  output logic [31:0]                 curStat,
  output logic                        irqOut
);
  localparam int HALF = 16;

  logic [NUM_SRC-1:0][1:0]       modeReg;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvlReg;
  logic [NUM_SRC-1:0]            syncIn;
  logic [NUM_SRC-1:0]            prevIn;
  logic [NUM_SRC-1:0]            edgeLatch;
  logic [NUM_SRC-1:0]            edgeHit;

  logic                          winFound;
  logic [LVL_W-1:0]              winLvl;
  logic [IDX_W-1:0]              winIdx;
  logic                          noReqReg;
  logic [LVL_W-1:0]              curLvlReg;
  logic [IDX_W-1:0]              curIdxReg;

  irqc_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (srcIn),
    .syncOut (syncIn)
  );

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enBit   <= 1'b0;
      maskVal <= '0;
      modeReg <= '0;
      lvlReg  <= '0;
    end else begin
      if (stb.wrEnable) enBit   <= stb.wdata[0];
      if (stb.wrMask)   maskVal <= stb.wdata[LVL_W-1:0];
      for (int n = 0; n < NUM_SRC; n++) begin
        if (stb.wrMode[(n % HALF) / 8])
          modeReg[n] <= stb.wdata[(n % 8) * 2 + (n / HALF) * 16 +: 2];
        if (stb.wrLevel[(n % HALF) / 2])
          lvlReg[n] <= stb.wdata[(n / HALF) * 16 + (n % 2) * 8 +: LVL_W];
      end
    end
  end

  // Edge detection and sticky requests
  always_comb begin
    for (int n = 0; n < NUM_SRC; n++) begin
      edgeHit[n] = modeReg[n][1] &&
                   (modeReg[n][0] ? (syncIn[n] && !prevIn[n])
                                  : (!syncIn[n] && prevIn[n]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevIn    <= '0;
      edgeLatch <= '0;
    end else begin
      prevIn <= syncIn;
      for (int n = 0; n < NUM_SRC; n++) begin
        if (edgeHit[n])
          edgeLatch[n] <= 1'b1;
        else if (stb.clrEdge && (stb.clrIdx == IDX_W'(n)))
          edgeLatch[n] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_SRC; n++) begin
      pendVec[n] = modeReg[n][1] ? edgeLatch[n] : (syncIn[n] == modeReg[n][0]);
    end
  end

  // Priority selection: strict compare keeps the lowest index on a tie
  always_comb begin
    winFound = 1'b0;
    winLvl   = '0;
    winIdx   = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (pendVec[n] && (lvlReg[n] > maskVal) && (!winFound || (lvlReg[n] > winLvl))) begin
        winFound = 1'b1;
        winLvl   = lvlReg[n];
        winIdx   = IDX_W'(n);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noReqReg  <= 1'b1;
      curLvlReg <= '0;
      curIdxReg <= '0;
      irqOut    <= 1'b0;
    end else begin
      noReqReg  <= !winFound;
      curLvlReg <= winLvl;
      curIdxReg <= winIdx;
      irqOut    <= enBit && winFound;
    end
  end

  assign curStat = {15'b0, noReqReg, 5'b0, curLvlReg, 3'b0, curIdxReg};

  // Readback images
  always_comb begin
    modeImg = '0;
    lvlImg  = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      modeImg[(n % HALF) / 8][(n % 8) * 2 + (n / HALF) * 16 +: 2] = modeReg[n];
      lvlImg[(n % HALF) / 2][(n / HALF) * 16 + (n % 2) * 8 +: LVL_W] = lvlReg[n];
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [7:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);
  irqcStrobe_t                 stb;
  logic                        enBit;
  logic [LVL_W-1:0]            maskVal;
  logic [MODE_REGS-1:0][31:0]  modeImg;
  logic [LVL_REGS-1:0][31:0]   lvlImg;
  logic [NUM_SRC-1:0]          pendVec;
  logic [31:0]                 curStat;

  irqc_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .stb      (stb),
    .enBit    (enBit),
    .maskVal  (maskVal),
    .modeImg  (modeImg),
    .lvlImg   (lvlImg),
    .pendVec  (pendVec),
    .curStat  (curStat)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .srcIn   (srcIn),
    .enBit   (enBit),
    .maskVal (maskVal),
    .modeImg (modeImg),
    .lvlImg  (lvlImg),
    .pendVec (pendVec),
    .curStat (curStat),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        enBit,
  input logic [2:0]  maskVal,
  input logic [31:0] curStat,
  input logic        irqOut
);
  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enBit |=> !irqOut);

  // R11
  irq_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> !curStat[16]);

  // R9
  winner_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !curStat[16] |-> (curStat[10:8] > $past(maskVal)));

  // R10
  idle_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    curStat[16] |-> (curStat[10:8] == 3'd0 && curStat[4:0] == 5'd0));

  // R10
  index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(curStat[4:0]) < NUM_SRC);

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curStat[31:17] == 15'd0) && (curStat[15:11] == 5'd0) && (curStat[7:5] == 3'd0));
endmodule

bind prio_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .enBit   (enBit),
  .maskVal (maskVal),
  .curStat (curStat),
  .irqOut  (irqOut)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NS-1:0] srcIn = '1;
  logic          irqOut;

  int checks = 0;
  int errors = 0;

  bit [1:0] mMode [NS];
  bit [2:0] mLvl  [NS];
  bit       mLatch[NS];
  bit [2:0] mMask = 0;
  bit       mEn = 0;
  bit [NS-1:0] mIn = '1;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NS)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcIn(srcIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  // Model of sticky requests on an input change (R6)
  task automatic setInputs(input logic [NS-1:0] v);
    for (int n = 0; n < NS; n++) begin
      if (mMode[n][1]) begin
        if (mMode[n][0] && !mIn[n] && v[n]) mLatch[n] = 1;
        if (!mMode[n][0] && mIn[n] && !v[n]) mLatch[n] = 1;
      end
    end
    mIn = v;
    @(negedge clk);
    srcIn = v;
  endtask

  function automatic logic [31:0] expPend();
    logic [31:0] p = '0;
    for (int n = 0; n < NS; n++)
      p[n] = mMode[n][1] ? mLatch[n] : (mIn[n] == mMode[n][0]);
    return p;
  endfunction

  function automatic logic [31:0] expCur();
    logic [31:0] p = expPend();
    bit found = 0; bit [2:0] bl = 0; int bi = 0;
    for (int n = 0; n < NS; n++)
      if (p[n] && mLvl[n] > mMask && (!found || mLvl[n] > bl)) begin
        found = 1; bl = mLvl[n]; bi = n;
      end
    return found ? ({29'b0, bl} << 8) | 32'(bi) : 32'h0001_0000;
  endfunction

  function automatic logic [31:0] expLvlWord(input int k);
    logic [31:0] w = '0;
    for (int n = 0; n < NS; n++)
      if ((n % 16) / 2 == k) w[(n / 16) * 16 + (n % 2) * 8 +: 3] = mLvl[n];
    return w;
  endfunction

  function automatic logic [31:0] expModeWord(input int r);
    logic [31:0] w = '0;
    for (int n = 0; n < NS; n++)
      if ((n % 16) / 8 == r) w[(n % 8) * 2 + (n / 16) * 16 +: 2] = mMode[n];
    return w;
  endfunction

  task automatic wrLevelReg(input int k, input logic [31:0] d);
    busWr(8'h10 + 8'(4 * k), d);
    for (int n = 0; n < NS; n++)
      if ((n % 16) / 2 == k) mLvl[n] = d[(n / 16) * 16 + (n % 2) * 8 +: 3];
  endtask

  task automatic wrModeReg(input int r, input logic [31:0] d);
    busWr(8'h04 + 8'(4 * r), d);
    for (int n = 0; n < NS; n++)
      if ((n % 16) / 8 == r) mMode[n] = d[(n % 8) * 2 + (n / 16) * 16 +: 2];
  endtask

  task automatic checkState(input string tag);
    logic [31:0] d;
    settle();
    busRd(8'hA0, d);  check({tag, " R10 curstat"}, d, expCur());
    busRd(8'h80, d);  check({tag, " R12 srcstat"}, d, expPend());
    check({tag, " R11 irqOut"}, 32'(irqOut), 32'(mEn && !expCur()[16]));
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NS-1:0] v;
    void'($urandom(32'd1234));
    for (int n = 0; n < NS; n++) begin mMode[n] = 0; mLvl[n] = 0; mLatch[n] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    settle();

    // R1 reset state
    busRd(8'h00, d); check("R1 enable", d, 0);
    busRd(8'h40, d); check("R1 mask", d, 0);
    busRd(8'h1C, d); check("R1 level", d, 0);
    busRd(8'h08, d); check("R1 mode", d, 0);
    busRd(8'hA0, d); check("R1 curstat", d, 32'h0001_0000);
    check("R1 irqOut", 32'(irqOut), 0);

    // R2 / R3 readback widths and packing
    busWr(8'h00, 32'hFFFF); busRd(8'h00, d); check("R2 enable bit", d, 1);
    busWr(8'h00, 0);
    busWr(8'h40, 32'hFF);   busRd(8'h40, d); check("R2 mask bits", d, 7);
    busWr(8'h40, 0);
    wrLevelReg(3, 32'hFFFF_FFFF); busRd(8'h1C, d); check("R3 lanes", d, 32'h0707_0707);
    wrLevelReg(3, 0);
    // R4: source 9 rising, source 25 falling -> register 1
    wrModeReg(1, 32'h0008_000C); busRd(8'h08, d); check("R4 mode pack", d, expModeWord(1));
    wrModeReg(1, 0);

    // R5/R9/R10/R11: source 5 active low at level 4
    busWr(8'h00, 1); mEn = 1;
    wrLevelReg(2, 32'h0000_0400);
    setInputs(~(32'h1 << 5));
    checkState("R5 low active");
    busRd(8'hA0, d); check("R10 src5", d, 32'h0000_0405);
    busWr(8'h40, 4); mMask = 4;
    checkState("R9 equal mask");
    busWr(8'h40, 3); mMask = 3;
    // R10 tie: sources 5 and 21 at level 4, then 20 at 6
    wrLevelReg(2, 32'h0400_0400);
    setInputs(~((32'h1 << 5) | (32'h1 << 21)));
    checkState("R10 tie");
    busRd(8'hA0, d); check("R10 tie lowest", d, 32'h0000_0405);
    wrLevelReg(2, 32'h0406_0400);
    setInputs(~((32'h1 << 5) | (32'h1 << 21) | (32'h1 << 20)));
    checkState("R10 highest");
    busRd(8'hA0, d); check("R10 highest lvl", d, 32'h0000_0614);
    // R11 disable
    busWr(8'h00, 0); mEn = 0;
    checkState("R11 disabled");
    check("R11 off", 32'(irqOut), 0);
    busWr(8'h00, 1); mEn = 1;
    // R5 active high on source 1
    wrModeReg(0, 32'h0000_0004); wrLevelReg(0, 32'h0000_0700);
    setInputs('1 & ~32'h2);
    checkState("R5 high idle");
    setInputs('1);
    checkState("R5 high active");

    // R6 rising edge on source 3
    wrModeReg(0, 32'h0000_00C4); wrLevelReg(1, 32'h0000_0700);
    setInputs(mIn & ~32'h8);
    checkState("R6 wrong dir");
    setInputs(mIn | 32'h8);
    setInputs(mIn & ~32'h8);
    checkState("R6 sticky");
    // R7 clear without enable bit is ignored, with it clears
    busWr(8'h60, 32'h0000_0003);
    checkState("R7 no bit8");
    busWr(8'h60, 32'h0000_0103); mLatch[3] = 0;
    checkState("R7 cleared");
    // R8 collision: rise commits on third edge, clear on same edge
    setInputs(mIn | 32'h8);
    @(posedge clk); @(posedge clk);
    busWr(8'h60, 32'h0000_0103);
    checkState("R8 edge wins");
    busWr(8'h60, 32'h0000_0103); mLatch[3] = 0;
    // R6 falling edge mode
    wrModeReg(0, 32'h0000_0084);
    setInputs(mIn & ~32'h8);
    checkState("R6 falling");
    busWr(8'h60, 32'h0000_0103); mLatch[3] = 0;
    checkState("R7 clear fall");

    // Random traffic
    for (int it = 0; it < 250; it++) begin
      case ($urandom % 6)
        0: wrLevelReg($urandom % 8, $urandom);
        1: wrModeReg($urandom % 2, $urandom);
        2: begin mMask = 3'($urandom % 8); busWr(8'h40, 32'(mMask)); end
        3: begin
             d = 32'($urandom % 32) | (($urandom % 4 != 0) ? 32'h100 : 32'h0);
             busWr(8'h60, d);
             if (d[8]) mLatch[d[4:0]] = 0;
           end
        default: begin v = mIn ^ (32'($urandom) & 32'($urandom)); setInputs(v); end
      endcase
      if (it % 50 == 0) begin mEn = ~mEn; busWr(8'h00, 32'(mEn)); end
      checkState("rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule